// File: doc/BRIEF.md
# Smart Card Transmit Status Flags

This block keeps the transmit-side status of a half-duplex smart card serial channel. It holds four flags: parity error, error signal (the card pulled the line low to reject a character), transmit data empty, and transmit end. The character shifter, retransmission logic and clock generator sit outside. They report events to this block as single-cycle strobes: a character has started, a parity error was found, an error signal was seen.

Transmit end does not rise as soon as the shifter goes idle. It rises after a mode-dependent delay measured from the start of each character, counted in half element time units (etu). One etu is `ETU_CYC` clock cycles. The delay is 5, 3 or 2 half-etu steps and is picked by two mode inputs, which are latched when the character starts. Software reads and clears the flags through an 8-bit status port. The usual clear is to read a flag as 1 and then write it as 0. A write to the transmit data register, made by software or by a transfer controller woken by the transmit interrupt, clears the data-empty and transmit-end flags directly.

Status byte layout: bit 0 transmit end (read only), bit 1 data empty, bit 2 error signal, bit 3 parity error, bit 4 multiprocessor bit (always reads 0), bit 5 multiprocessor transfer bit (plain read/write, software keeps it 0), bits 7:6 read 0.

Top module: `sc_txstat`

## Requirements
- R1: After reset the status byte reads 0x03: transmit end 1, data empty 1, and every other bit 0.
- R2: A `par_err` or `err_sig` strobe sets the parity error flag (bit 3) or the error signal flag (bit 2) at the next clock edge.
- R3: A flag in bits 3..1 clears when a `bus_wr` with that bit at 0 follows a `bus_rd` that returned the bit as 1, with no other write in between.
- R4: Writing 1 to a flag bit leaves it unchanged. Writing 0 to a flag that was not read as 1 since the last write also leaves it unchanged.
- R5: While `tx_en` and the error signal flag are both 0, transmit end reads 1 from the next clock edge on. With `tx_en` at 0 and the error signal flag at 1, it is not forced.
- R6: Transmit end rises exactly D*`ETU_CYC`/2 cycles after the edge that samples `byte_start`. D is 5 for {`mode_short`,`mode_block`}=00, 3 for 01, and 2 for 10 or 11.
- R7: The timed rise of transmit end happens only when, at that moment, the error signal flag is 0 and the data-empty flag is 1.
- R8: Clearing the data-empty flag through the read-then-write-0 handshake also clears transmit end.
- R9: A `tdr_wr` strobe clears both the data-empty flag and transmit end at the next edge.
- R10: A `byte_start` that arrives while a delay is running restarts the count with the newly selected mode, and the earlier rise is dropped.
- R11: `txi` is high exactly when transmit end is 1 and `txi_en` is 1.
- R12: Bit 4 always reads 0. Bit 5 holds the value last written to it.
- R13: A `byte_start` strobe sets the data-empty flag at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enabled |
| mode_short | input | 1 | Short guard-time mode (delay 2 half-etu) |
| mode_block | input | 1 | Block mode (delay 3 half-etu when not short) |
| byte_start | input | 1 | Strobe: a character transfer starts |
| par_err | input | 1 | Strobe: parity error detected |
| err_sig | input | 1 | Strobe: error signal detected |
| bus_rd | input | 1 | Status read strobe |
| bus_wr | input | 1 | Status write strobe |
| bus_wdata | input | 8 | Status write data |
| bus_rdata | output | 8 | Status read data |
| tdr_wr | input | 1 | Strobe: transmit data register written |
| txi_en | input | 1 | Transmit interrupt enable |
| txi | output | 1 | Transmit interrupt request |
| per_flag | output | 1 | Parity error flag |
| ers_flag | output | 1 | Error signal flag |
| tdre_flag | output | 1 | Transmit data empty flag |
| tend_flag | output | 1 | Transmit end flag |

## Verification
The assertions assume that every event input is a one-cycle strobe and that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume `ETU_CYC` is even and at least 2. The bench drives every strobe for exactly one cycle between falling edges and never issues a read and a write together. It moves `tx_en` and the mode inputs only at falling edges, and it keeps `tdr_wr` away from the edge on which a delay runs out, because at that edge the clear takes priority over the rise.

// File: rtl/sc_txstat_pkg.sv
package sc_txstat_pkg;

  // Handshake flag indices
  localparam int FI_TDRE = 0;
  localparam int FI_ERS  = 1;
  localparam int FI_PER  = 2;
  localparam int NFLAG   = 3;

  // Status byte positions
  localparam int BP_TEND = 0;
  localparam int BP_MPB  = 4;
  localparam int BP_MPBT = 5;

  // Status bit carried by each handshake flag
  function automatic int flag_bit(input int idx);
    return idx + 1;
  endfunction

  // Reset level of each handshake flag
  function automatic logic flag_rst(input int idx);
    return (idx == FI_TDRE);
  endfunction

  // Half-etu steps from character start to transmit end
  function automatic logic [2:0] halves_for_mode(input logic short_g, input logic blk);
    if (short_g) return 3'd2;
    else if (blk) return 3'd3;
    else return 3'd5;
  endfunction

endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int ETU_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic short_g,
  input  logic blk,
  output logic fire,
  output logic busy
);
  import sc_txstat_pkg::*;

  localparam int HALF = ETU_CYC / 2;
  localparam int PW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PW-1:0] pre_q;
  logic [2:0]    half_q;
  logic [2:0]    tgt_q;
  logic          act_q;
  logic          tick;

  assign tick = act_q && (pre_q == PW'(HALF - 1));
  assign fire = tick && ((half_q + 3'd1) == tgt_q);
  assign busy = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      half_q <= '0;
      tgt_q  <= 3'd5;
      act_q  <= 1'b0;
    end else if (start) begin
      pre_q  <= '0;
      half_q <= '0;
      tgt_q  <= halves_for_mode(short_g, blk);
      act_q  <= 1'b1;
    end else if (act_q) begin
      if (tick) begin
        pre_q  <= '0;
        half_q <= half_q + 3'd1;
        if (fire) act_q <= 1'b0;
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  // R6
  half_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (half_q < tgt_q));

  // R10
  restart_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (act_q && half_q == 3'd0 && pre_q == '0));

endmodule

// File: rtl/sc_hs_flag.sv
module sc_hs_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic alt_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic hs_clr_o
);
  logic flag_q;
  logic arm_q;

  assign hs_clr_o = wr_i && arm_q && !wbit_i;
  assign flag_o   = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (wr_i) begin
      arm_q <= 1'b0;
    end else if (rd_i) begin
      arm_q <= flag_q;
    end else begin
      arm_q <= arm_q && flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     flag_q <= RST_VAL;
    else if (set_i)                 flag_q <= 1'b1;
    else if (hs_clr_o || alt_clr_i) flag_q <= 1'b0;
  end

  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R3
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(hs_clr_o || alt_clr_i));

  // R4
  write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wbit_i && !alt_clr_i && flag_q) |=> flag_q);

endmodule

// File: rtl/sc_tend_ctrl.sv
module sc_tend_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic ers,
  input  logic tdre,
  input  logic fire,
  input  logic tdre_hs_clr,
  input  logic tdr_wr,
  output logic tend
);
  logic tend_q;
  logic forced;
  logic fire_ok;
  logic clr;

  assign forced  = !tx_en && !ers;
  assign fire_ok = fire && !ers && tdre;
  assign clr     = tdre_hs_clr || tdr_wr;
  assign tend    = tend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tend_q <= 1'b1;
    else if (forced)  tend_q <= 1'b1;
    else if (clr)     tend_q <= 1'b0;
    else if (fire_ok) tend_q <= 1'b1;
  end

  // R5
  forced_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> tend_q);

  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend_q) |-> $past(forced || fire_ok));

  // R8
  clear_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !forced) |=> !tend_q);

endmodule

// File: rtl/sc_txstat.sv
module sc_txstat #(
  parameter int ETU_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       mode_short,
  input  logic       mode_block,
  input  logic       byte_start,
  input  logic       par_err,
  input  logic       err_sig,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tdr_wr,
  input  logic       txi_en,
  output logic       txi,
  output logic       per_flag,
  output logic       ers_flag,
  output logic       tdre_flag,
  output logic       tend_flag
);
  import sc_txstat_pkg::*;

  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] alt_v;
  logic [NFLAG-1:0] flag_v;
  logic [NFLAG-1:0] hs_v;
  logic             fire;
  logic             timer_busy;
  logic             mpbt_q;
  logic             unused_sig;

  assign set_v[FI_TDRE] = byte_start;
  assign set_v[FI_ERS]  = err_sig;
  assign set_v[FI_PER]  = par_err;
  assign alt_v[FI_TDRE] = tdr_wr;
  assign alt_v[FI_ERS]  = 1'b0;
  assign alt_v[FI_PER]  = 1'b0;

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    localparam int BP = flag_bit(gi);
    sc_hs_flag #(.RST_VAL(flag_rst(gi))) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_v[gi]),
      .alt_clr_i(alt_v[gi]),
      .rd_i     (bus_rd),
      .wr_i     (bus_wr),
      .wbit_i   (bus_wdata[BP]),
      .flag_o   (flag_v[gi]),
      .hs_clr_o (hs_v[gi])
    );
  end

  sc_etu_timer #(.ETU_CYC(ETU_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (byte_start),
    .short_g(mode_short),
    .blk    (mode_block),
    .fire   (fire),
    .busy   (timer_busy)
  );

  sc_tend_ctrl u_tend (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .ers        (flag_v[FI_ERS]),
    .tdre       (flag_v[FI_TDRE]),
    .fire       (fire),
    .tdre_hs_clr(hs_v[FI_TDRE]),
    .tdr_wr     (tdr_wr),
    .tend       (tend_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      mpbt_q <= 1'b0;
    else if (bus_wr) mpbt_q <= bus_wdata[BP_MPBT];
  end

  always_comb begin
    bus_rdata = '0;
    bus_rdata[BP_TEND] = tend_flag;
    for (int i = 0; i < NFLAG; i++) bus_rdata[flag_bit(i)] = flag_v[i];
    bus_rdata[BP_MPB]  = 1'b0;
    bus_rdata[BP_MPBT] = mpbt_q;
  end

  assign per_flag  = flag_v[FI_PER];
  assign ers_flag  = flag_v[FI_ERS];
  assign tdre_flag = flag_v[FI_TDRE];
  assign txi       = tend_flag && txi_en;
  assign unused_sig = ^{bus_wdata[7:6], bus_wdata[BP_MPB], bus_wdata[BP_TEND], timer_busy};

  // R9
  tdr_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tdr_wr && !byte_start && !(!tx_en && !ers_flag)) |=> (!tdre_flag && !tend_flag));

  // R13
  start_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_start |=> tdre_flag);

endmodule

// File: tb/tb_sc_txstat.sv
module tb_sc_txstat;
  localparam int ETU = 8;

  localparam logic [3:0] OP_END = 4'd0, OP_TE = 4'd1, OP_READ = 4'd2, OP_WRITE = 4'd3,
                         OP_PEEK = 4'd4, OP_START = 4'd5, OP_WAIT = 4'd6, OP_TDRW = 4'd7,
                         OP_ERS = 4'd8;

  // {req, op, arg, expected}
  localparam int NV = 61;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {4'd5,  OP_TE,    8'd1,  8'h00},  // R5 enable transmitter
    {4'd1,  OP_READ,  8'd0,  8'h03},  // R1 reset value
    {4'd8,  OP_WRITE, 8'h00, 8'h00},  // R8 handshake clear of empty
    {4'd8,  OP_PEEK,  8'd0,  8'h00},
    {4'd13, OP_START, 8'd0,  8'h00},  // R13
    {4'd13, OP_PEEK,  8'd0,  8'h02},
    {4'd6,  OP_WAIT,  8'd19, 8'h00},  // R6 mode 00: 20 cycles
    {4'd6,  OP_PEEK,  8'd0,  8'h02},
    {4'd6,  OP_WAIT,  8'd1,  8'h00},
    {4'd6,  OP_PEEK,  8'd0,  8'h03},
    {4'd3,  OP_READ,  8'd0,  8'h03},  // R3
    {4'd8,  OP_WRITE, 8'h00, 8'h00},
    {4'd8,  OP_PEEK,  8'd0,  8'h00},
    {4'd13, OP_START, 8'd1,  8'h00},  // R6 mode 01: 12 cycles
    {4'd6,  OP_WAIT,  8'd11, 8'h00},
    {4'd6,  OP_PEEK,  8'd0,  8'h02},
    {4'd6,  OP_WAIT,  8'd1,  8'h00},
    {4'd6,  OP_PEEK,  8'd0,  8'h03},
    {4'd4,  OP_READ,  8'd0,  8'h03},  // R4 write 1 keeps
    {4'd4,  OP_WRITE, 8'h02, 8'h00},
    {4'd4,  OP_PEEK,  8'd0,  8'h03},
    {4'd4,  OP_WRITE, 8'h00, 8'h00},  // R4 no read before write
    {4'd4,  OP_PEEK,  8'd0,  8'h03},
    {4'd9,  OP_TDRW,  8'd0,  8'h00},  // R9
    {4'd9,  OP_PEEK,  8'd0,  8'h00},
    {4'd13, OP_START, 8'd2,  8'h00},  // R6 mode 10: 8 cycles
    {4'd6,  OP_WAIT,  8'd7,  8'h00},
    {4'd6,  OP_PEEK,  8'd0,  8'h02},
    {4'd6,  OP_WAIT,  8'd1,  8'h00},
    {4'd6,  OP_PEEK,  8'd0,  8'h03},
    {4'd9,  OP_TDRW,  8'd0,  8'h00},
    {4'd13, OP_START, 8'd3,  8'h00},  // R6 mode 11: 8 cycles
    {4'd6,  OP_WAIT,  8'd7,  8'h00},
    {4'd6,  OP_PEEK,  8'd0,  8'h02},
    {4'd6,  OP_WAIT,  8'd1,  8'h00},
    {4'd6,  OP_PEEK,  8'd0,  8'h03},
    {4'd9,  OP_TDRW,  8'd0,  8'h00},
    {4'd10, OP_START, 8'd2,  8'h00},  // R10 short delay, then restart long
    {4'd10, OP_WAIT,  8'd4,  8'h00},
    {4'd10, OP_START, 8'd0,  8'h00},
    {4'd10, OP_WAIT,  8'd4,  8'h00},
    {4'd10, OP_PEEK,  8'd0,  8'h02},
    {4'd10, OP_WAIT,  8'd15, 8'h00},
    {4'd10, OP_PEEK,  8'd0,  8'h02},
    {4'd10, OP_WAIT,  8'd1,  8'h00},
    {4'd10, OP_PEEK,  8'd0,  8'h03},
    {4'd9,  OP_TDRW,  8'd0,  8'h00},
    {4'd13, OP_START, 8'd2,  8'h00},  // R7 error signal blocks rise
    {4'd2,  OP_ERS,   8'd0,  8'h00},
    {4'd2,  OP_PEEK,  8'd0,  8'h06},
    {4'd7,  OP_WAIT,  8'd8,  8'h00},
    {4'd7,  OP_PEEK,  8'd0,  8'h06},
    {4'd5,  OP_TE,    8'd0,  8'h00},  // R5 not forced while error set
    {4'd5,  OP_WAIT,  8'd1,  8'h00},
    {4'd5,  OP_PEEK,  8'd0,  8'h06},
    {4'd3,  OP_READ,  8'd0,  8'h06},
    {4'd3,  OP_WRITE, 8'h02, 8'h00},
    {4'd5,  OP_PEEK,  8'd0,  8'h02},
    {4'd5,  OP_WAIT,  8'd1,  8'h00},
    {4'd5,  OP_PEEK,  8'd0,  8'h03},
    {4'd0,  OP_END,   8'd0,  8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, mode_short = 0, mode_block = 0, byte_start = 0, par_err = 0, err_sig = 0;
  logic bus_rd = 0, bus_wr = 0, tdr_wr = 0, txi_en = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic txi, per_flag, ers_flag, tdre_flag, tend_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sc_txstat #(.ETU_CYC(ETU)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mode_short(mode_short), .mode_block(mode_block),
    .byte_start(byte_start), .par_err(par_err), .err_sig(err_sig), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tdr_wr(tdr_wr),
    .txi_en(txi_en), .txi(txi), .per_flag(per_flag), .ers_flag(ers_flag),
    .tdre_flag(tdre_flag), .tend_flag(tend_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    @(negedge clk); bus_rd = 1'b1; #1;
    chk(req, bus_rdata, exp);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: all R tags, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", bus_rdata, 8'h03);
    chk("R1", {4'd0, per_flag, ers_flag, tdre_flag, tend_flag}, 8'h03);
    chk("R11", {7'd0, txi}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq, op;
      logic [7:0] arg, exp;
      string tag;
      {rq, op, arg, exp} = VEC[i];
      tag = $sformatf("R%0d step %0d", rq, i);
      if (op == OP_END) break;
      case (op)
        OP_TE:    begin @(negedge clk); tx_en = arg[0]; end
        OP_READ:  do_read(tag, exp);
        OP_WRITE: do_write(arg);
        OP_PEEK:  chk(tag, bus_rdata, exp);
        OP_START: begin
          @(negedge clk); byte_start = 1'b1; mode_short = arg[1]; mode_block = arg[0];
          @(negedge clk); byte_start = 1'b0;
        end
        OP_WAIT:  repeat (arg) @(negedge clk);
        OP_TDRW:  begin @(negedge clk); tdr_wr = 1'b1; @(negedge clk); tdr_wr = 1'b0; end
        OP_ERS:   begin @(negedge clk); err_sig = 1'b1; @(negedge clk); err_sig = 1'b0; end
        default: ;
      endcase
    end

    // R2 parity error set, R3 cleared by handshake
    @(negedge clk); par_err = 1'b1;
    @(negedge clk); par_err = 1'b0;
    chk("R2", bus_rdata, 8'h0B);
    chk("R2", {7'd0, per_flag}, 8'h01);
    do_read("R3", 8'h0B);
    do_write(8'h07);
    chk("R3", bus_rdata, 8'h03);

    // R12 spare bits
    do_write(8'h20);
    chk("R12", bus_rdata, 8'h23);
    do_write(8'h10);
    chk("R12", bus_rdata, 8'h03);

    // R11 interrupt request
    @(negedge clk); txi_en = 1'b1; #1;
    chk("R11", {7'd0, txi}, 8'h01);
    tx_en = 1'b1;
    @(negedge clk); tdr_wr = 1'b1;
    @(negedge clk); tdr_wr = 1'b0;
    chk("R9", {6'd0, tdre_flag, tend_flag}, 8'h00);
    chk("R11", {7'd0, txi}, 8'h00);
    txi_en = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule